// File: doc/BRIEF.md
# Station Ring and Call Sequencer

The sequencer runs the calling side of a party-line telephone station. It waits idle until one of three request sources fires. The sources are an address-match pulse from a tone decoder, or a trunk signalling lead of either polarity. It then rings the handset in bursts. During each burst, an enable toggles at the ringer frequency. A quiet gap follows each burst, and the pattern repeats until a fixed ring period runs out. Each burst is also reported on an acknowledge output and, unless the call is a broadcast, on a ringback enable toward the line. A broadcast flag switches the bursts to a short, fast pattern.

The hook input has two uses. A synchronized copy trips ringing within a few cycles of the handset lifting. A debounced copy decides whether the station is off hook, and that in turn drives the trunk busy lead and opens the transmit path. A user who lifts the handset while idle goes straight to the talk state. Replacing the handset returns the block to idle. All times are counted in ticks of a shared prescaler, and every count is a parameter.

Top module: `ring_call_ctrl`

## Requirements
- R1: After reset, all five outputs are low.
- R2: While idle and on hook, ringing starts one clock after any of the following: a rising edge of addr_hit_i, elead_pos_i going high, or elead_neg_i going low.
- R3: Ringing begins with a burst of ON_TICKS ticks. Gaps of OFF_TICKS ticks alternate with further bursts, and ack_o is high exactly during bursts. Ringing stops after RING_TICKS ticks. With the bench values this gives three bursts.
- R4: ring_en_o is high only inside a burst. Each burst starts with ring_en_o high, and ring_en_o then toggles every TONE_HALF ticks.
- R5: If hook_i goes high while ringing, ack_o and ring_en_o fall within three clocks. mlead_o does not rise until the debounce period has passed.
- R6: A change of hook_i is accepted only after it has held for DEB_TICKS ticks. Shorter pulses leave mlead_o unchanged.
- R7: tx_en_o is high only in the talk state. That state is entered when the debounced hook is off hook, either after a ring trip or from idle when the user goes off hook to place a call.
- R8: ringback_o is high during bursts while all_call_i is low, and stays low for the whole call while all_call_i is high.
- R9: While all_call_i is high, bursts last RAPID_ON ticks and gaps last RAPID_OFF ticks. With the bench values this gives ten bursts in one ring period.
- R10: A new request during ringing or during talk has no effect. A request held level past the end of the ring period does not start a second ring period.
- R11: Once the debounced hook returns on hook, the block goes idle and tx_en_o and mlead_o fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_hit_i | input | 1 | Address-match request; rising edge requests ringing |
| elead_pos_i | input | 1 | Signalling lead, active high |
| elead_neg_i | input | 1 | Signalling lead, active low |
| all_call_i | input | 1 | Broadcast: rapid cadence, no ringback |
| hook_i | input | 1 | Raw hook state, 1 = off hook |
| ring_en_o | output | 1 | Ringer enable, toggling at ringer rate during bursts |
| ack_o | output | 1 | High during ring bursts |
| ringback_o | output | 1 | Ringback tone enable toward the line |
| mlead_o | output | 1 | Debounced off-hook indication |
| tx_en_o | output | 1 | Transmit path enable |

## Verification
Two events can land in the same cycle. The first is a ring trip that arrives while a burst is active, so that the cadence counter is about to advance. The bench provokes this by lifting the hook in the middle of a burst. It judges the result by requiring the burst and ringer outputs to drop within three clocks while the busy lead stays low until debounce completes. The second is a fresh request that arrives while ringing or talking. The bench issues one in each state. It judges the result by the number of bursts and by ack_o staying low during talk.

// File: rtl/ring_ctrl_pkg.sv
package ring_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RING = 2'd1,
    ST_TRIP = 2'd2,
    ST_TALK = 2'd3
  } call_st_e;
endpackage

// File: rtl/ring_tick_gen.sv
module ring_tick_gen #(
  parameter int TICK_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICK_CYC <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(TICK_CYC);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         cnt_q <= '0;
        else if (cnt_q == CW'(TICK_CYC - 1)) cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(TICK_CYC - 1));
    end
  endgenerate
endmodule

// File: rtl/ring_hook_deb.sv
module ring_hook_deb #(
  parameter int DEB_TICKS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hook_i,
  output logic hook_sync_o,
  output logic hook_stable_o
);
  localparam int DW = $clog2(DEB_TICKS + 1);
  logic [1:0]    sync_q;
  logic [DW-1:0] cnt_q;
  logic          stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '0;
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], hook_i};
      if (sync_q[1] == stable_q) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == DW'(DEB_TICKS - 1)) begin
          stable_q <= sync_q[1];
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign hook_sync_o   = sync_q[1];
  assign hook_stable_o = stable_q;
endmodule

// File: rtl/ring_cadence.sv
module ring_cadence #(
  parameter int ON_TICKS   = 2000,
  parameter int OFF_TICKS  = 4000,
  parameter int RAPID_ON   = 500,
  parameter int RAPID_OFF  = 500,
  parameter int TONE_HALF  = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic run_i,
  input  logic rapid_i,
  output logic burst_o,
  output logic tone_o
);
  localparam int MAXL = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
  localparam int PW   = $clog2(MAXL + 1);
  localparam int TW   = $clog2(TONE_HALF + 1);

  logic [PW-1:0] ph_q;
  logic [TW-1:0] tc_q;
  logic          burst_q, tone_q;
  logic [PW-1:0] len_last;

  always_comb begin
    if (rapid_i) len_last = burst_q ? PW'(RAPID_ON - 1) : PW'(RAPID_OFF - 1);
    else         len_last = burst_q ? PW'(ON_TICKS - 1) : PW'(OFF_TICKS - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      tc_q    <= '0;
      burst_q <= 1'b0;
      tone_q  <= 1'b0;
    end else if (start_i) begin
      ph_q    <= '0;
      tc_q    <= '0;
      burst_q <= 1'b1;
      tone_q  <= 1'b1;
    end else if (run_i && tick_i) begin
      if (ph_q >= len_last) begin
        ph_q    <= '0;
        burst_q <= ~burst_q;
        tone_q  <= 1'b1;
        tc_q    <= '0;
      end else begin
        ph_q <= ph_q + 1'b1;
        if (burst_q) begin
          if (tc_q == TW'(TONE_HALF - 1)) begin
            tc_q   <= '0;
            tone_q <= ~tone_q;
          end else begin
            tc_q <= tc_q + 1'b1;
          end
        end
      end
    end
  end

  assign burst_o = burst_q;
  assign tone_o  = tone_q;
endmodule

// File: rtl/ring_call_ctrl.sv
module ring_call_ctrl
  import ring_ctrl_pkg::*;
#(
  parameter int TICK_CYC   = 50000,
  parameter int RING_TICKS = 19000,
  parameter int ON_TICKS   = 2000,
  parameter int OFF_TICKS  = 4000,
  parameter int RAPID_ON   = 500,
  parameter int RAPID_OFF  = 500,
  parameter int TONE_HALF  = 25,
  parameter int DEB_TICKS  = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic addr_hit_i,
  input  logic elead_pos_i,
  input  logic elead_neg_i,
  input  logic all_call_i,
  input  logic hook_i,
  output logic ring_en_o,
  output logic ack_o,
  output logic ringback_o,
  output logic mlead_o,
  output logic tx_en_o
);
  localparam int RW = $clog2(RING_TICKS + 1);

  logic tick, hook_sync, hook_db, burst, tone;
  logic req, req_q, req_rise, start;
  logic [RW-1:0] ring_q;
  call_st_e st_q, st_d;

  ring_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  ring_hook_deb #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .hook_i(hook_i),
    .hook_sync_o(hook_sync), .hook_stable_o(hook_db));

  ring_cadence #(
    .ON_TICKS(ON_TICKS), .OFF_TICKS(OFF_TICKS), .RAPID_ON(RAPID_ON),
    .RAPID_OFF(RAPID_OFF), .TONE_HALF(TONE_HALF)
  ) u_cad (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .start_i(start),
    .run_i(st_q == ST_RING), .rapid_i(all_call_i),
    .burst_o(burst), .tone_o(tone));

  // any source counts; only its leading edge requests
  assign req      = addr_hit_i | elead_pos_i | ~elead_neg_i;
  assign req_rise = req & ~req_q;
  assign start    = (st_q == ST_IDLE) && !hook_db && req_rise;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (hook_db) st_d = ST_TALK;
               else if (req_rise) st_d = ST_RING;
      ST_RING: if (hook_sync) st_d = ST_TRIP;
               else if (tick && ring_q == RW'(RING_TICKS - 1)) st_d = ST_IDLE;
      ST_TRIP: if (hook_db) st_d = ST_TALK;
               else if (!hook_sync) st_d = ST_IDLE;
      ST_TALK: if (!hook_db) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      req_q  <= 1'b0;
      ring_q <= '0;
    end else begin
      st_q  <= st_d;
      req_q <= req;
      if (start)                         ring_q <= '0;
      else if (st_q == ST_RING && tick)  ring_q <= ring_q + 1'b1;
    end
  end

  assign ack_o      = (st_q == ST_RING) && burst;
  assign ring_en_o  = (st_q == ST_RING) && burst && tone;
  assign ringback_o = (st_q == ST_RING) && burst && !all_call_i;
  assign mlead_o    = hook_db;
  assign tx_en_o    = (st_q == ST_TALK);
endmodule

// File: rtl/ring_call_ctrl_chk.sv
module ring_call_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ack_o,
  input logic ring_en_o,
  input logic mlead_o,
  input logic tx_en_o,
  input logic hook_sync
);
  p_burst_starts_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> ring_en_o);

  p_trip_stops_ring_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hook_sync && ack_o) |=> !ack_o);

  p_mlead_follows_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mlead_o) |-> $past(hook_sync));

  p_tx_needs_offhook_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> $past(mlead_o));

  p_onhook_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mlead_o) |=> !tx_en_o);
endmodule

bind ring_call_ctrl ring_call_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_o(ack_o), .ring_en_o(ring_en_o),
  .mlead_o(mlead_o), .tx_en_o(tx_en_o), .hook_sync(hook_sync));

// File: tb/ring_call_ctrl_test.sv
`timescale 1ns/1ps
module ring_call_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_hit = 1'b0, e_pos = 1'b0, e_neg = 1'b1, all_call = 1'b0, hook = 1'b0;
  logic ring_en, ack, rb, mlead, tx_en;
  int n_vec = 0, n_err = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  ring_call_ctrl #(
    .TICK_CYC(4), .RING_TICKS(60), .ON_TICKS(8), .OFF_TICKS(12),
    .RAPID_ON(3), .RAPID_OFF(3), .TONE_HALF(2), .DEB_TICKS(5)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_hit_i(addr_hit), .elead_pos_i(e_pos),
    .elead_neg_i(e_neg), .all_call_i(all_call), .hook_i(hook),
    .ring_en_o(ring_en), .ack_o(ack), .ringback_o(rb), .mlead_o(mlead), .tx_en_o(tx_en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      chk(0, "watchdog", cyc, 200000);
      finish_run();
    end
  end

  task automatic monitor(input int n, output int ack_r, output int rb_r,
                         output int re_r, output int bad, output int hi);
    logic pa = 1'b0, pr = 1'b0, pe = 1'b0;
    ack_r = 0; rb_r = 0; re_r = 0; bad = 0; hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ack && !pa) ack_r++;
      if (rb && !pr) rb_r++;
      if (ring_en && !pe) re_r++;
      if (ring_en && !ack) bad++;
      if (ack) hi++;
      pa = ack; pr = rb; pe = ring_en;
    end
  endtask

  task automatic pulse_addr();
    @(negedge clk) addr_hit = 1'b1;
    @(negedge clk) addr_hit = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk({ring_en, ack, rb, mlead, tx_en} == 5'b0, "R1 in reset", {ring_en, ack, rb, mlead, tx_en}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({ring_en, ack, rb, mlead, tx_en} == 5'b0, "R1 after reset", {ring_en, ack, rb, mlead, tx_en}, 0);
  endtask

  task automatic t_normal();
    int a, r, e, b, h;
    pulse_addr();
    chk(ack == 1'b1, "R2 addr_hit start", ack, 1);
    monitor(300, a, r, e, b, h);
    chk(a == 3, "R3 burst count", a, 3);
    chk(h >= 90 && h <= 96, "R3 burst length", h, 96);
    chk(e == 6, "R4 ringer pulses", e, 6);
    chk(b == 0, "R4 ringer outside burst", b, 0);
    chk(r == 3, "R8 ringback bursts", r, 3);
    chk(ack == 1'b0, "R3 ring time over", ack, 0);
  endtask

  task automatic t_elead();
    int a, r, e, b, h;
    @(negedge clk) e_pos = 1'b1;
    @(negedge clk);
    chk(ack == 1'b1, "R2 positive lead", ack, 1);
    repeat (5) @(negedge clk);
    e_pos = 1'b0;
    repeat (260) @(negedge clk);
    @(negedge clk) e_neg = 1'b0;
    @(negedge clk);
    chk(ack == 1'b1, "R2 negative lead", ack, 1);
    monitor(360, a, r, e, b, h);
    chk(a == 1 + 2, "R10 held lead no restart", a, 3);
    chk(ack == 1'b0, "R10 idle with lead held", ack, 0);
    e_neg = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_rapid();
    int a, r, e, b, h;
    all_call = 1'b1;
    pulse_addr();
    monitor(300, a, r, e, b, h);
    chk(a == 10, "R9 rapid burst count", a, 10);
    chk(r == 0, "R8 no ringback on broadcast", r, 0);
    all_call = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_second_req();
    int a, r, e, b, h, a2;
    pulse_addr();
    monitor(50, a, r, e, b, h);
    pulse_addr();
    monitor(250, a2, r, e, b, h);
    chk(a + a2 == 3, "R10 request while ringing", a + a2, 3);
    chk(ack == 1'b0, "R10 no extension", ack, 0);
  endtask

  task automatic t_trip();
    pulse_addr();
    while (!ack) @(negedge clk);
    repeat (10) @(negedge clk);
    hook = 1'b1;
    repeat (4) @(negedge clk);
    chk(ack == 1'b0 && ring_en == 1'b0, "R5 trip stops ring", ack, 0);
    chk(mlead == 1'b0, "R5 busy waits for debounce", mlead, 0);
    repeat (40) @(negedge clk);
    chk(mlead == 1'b1, "R5 busy after debounce", mlead, 1);
    chk(tx_en == 1'b1, "R7 talk after trip", tx_en, 1);
    pulse_addr();
    repeat (20) @(negedge clk);
    chk(ack == 1'b0, "R10 request during talk", ack, 0);
    hook = 1'b0;
    repeat (40) @(negedge clk);
    chk(mlead == 1'b0 && tx_en == 1'b0, "R11 back on hook", {mlead, tx_en}, 0);
  endtask

  task automatic t_glitch_and_caller();
    int seen = 0;
    @(negedge clk) hook = 1'b1;
    repeat (8) @(negedge clk);
    hook = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (mlead || tx_en) seen++;
    end
    chk(seen == 0, "R6 short hook pulse ignored", seen, 0);
    hook = 1'b1;
    repeat (40) @(negedge clk);
    chk(mlead == 1'b1 && tx_en == 1'b1, "R7 caller off hook", {mlead, tx_en}, 3);
    chk(ack == 1'b0, "R7 no ring when caller", ack, 0);
    hook = 1'b0;
    repeat (40) @(negedge clk);
    chk(tx_en == 1'b0, "R11 caller hangs up", tx_en, 0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_elead();
    t_rapid();
    t_second_req();
    t_trip();
    t_glitch_and_caller();
    finish_run();
  end
endmodule